// File: doc/BRIEF.md
# Windowed Watchdog Timer with Power-Mode Handling

A supervision timer built on a 7-bit down-counter. A prescaler divides the clock, and the counter drops by one on each prescaler tick. When the top bit of the counter falls, the block raises its reset output for one tick. The counter then returns to 7Fh and the software enable is cleared. Software keeps the timer alive by writing a new count. Such a write is accepted only once the count has fallen to or below a programmed window value. A write made too early raises the reset instead.

The block also follows the processor's low-power requests. A halt request either becomes a reset, or is granted with one final decrement and a frozen counter, depending on a configuration input. An active-halt request freezes the counter at once. A wake interrupt resumes counting, after a selectable restart delay when leaving halt and immediately when leaving active-halt. A hardware option input keeps the timer running whatever the software enable says. The counter is visible on an output port.

Top module: `window_watchdog`

## Requirements
- R1: While `rst_n` is low and after it is released, `count` is 7Fh, the window is 7Fh, the software enable is 0, and `wdg_rst` and `halt_ok` are low. `wdg_on` is high only if `hw_wdg` is high.
- R2: While running and active (`wdg_on` high), `count` falls by one every 2^PW clock cycles. Every accepted control write clears the prescaler, so the next decrement comes a full 2^PW cycles after that write.
- R3: When a tick moves `count` bit 6 from 1 to 0 (40h to 3Fh), `wdg_rst` rises in the same cycle that `count` shows 3Fh. It stays high for exactly 2^PW cycles. The block then returns to the R1 state (count 7Fh, window 7Fh, enable 0) and enters the restart delay.
- R4: A control write carries the enable in bit 7 and the new count in bits 6:0. A window write carries the window in bits 6:0. While active, a control write is accepted only when `count` is less than or equal to the window. When `count` is above the window, the write raises `wdg_rst` instead and `count` is left unchanged.
- R5: A control write that would leave the timer active with data bit 6 at 0 raises `wdg_rst`.
- R6: The software enable is set by writing 1 to bit 7. Writing 0 there leaves it set. Only `rst_n` or the end of a reset pulse clears it.
- R7: A halt request while active with `halt_cfg` at 0 raises `wdg_rst`, and `halt_ok` stays low.
- R8: A halt request with `halt_cfg` at 1, or while inactive, raises `halt_ok`. If the timer is active, `count` is decremented once. `count` is then frozen and no reset is raised while halted.
- R9: A wake interrupt in halt lowers `halt_ok`. The counter stays frozen for DLY_S cycles (`long_dly` low) or DLY_L cycles (`long_dly` high), and counting then resumes.
- R10: An active-halt request raises `halt_ok` without decrementing and without a reset, whatever `halt_cfg` is. A wake interrupt resumes counting at once, and the first decrement comes 2^PW cycles later.
- R11: After `rst_n` is released, counting is held for the restart delay of R9 before the first prescaler cycle.
- R12: With `hw_wdg` high, `wdg_on` is high and the timer counts and bites whatever the software enable is. It stays on after a reset pulse.
- R13: Control writes, window writes and halt requests have no effect while halted, in active-halt, or while `wdg_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_ctrl | input | 1 | Control write strobe (enable and count) |
| wr_win | input | 1 | Window write strobe |
| wr_data | input | CW+1 | Write data: bit CW enable, bits CW-1:0 count or window |
| hw_wdg | input | 1 | Hardware always-on option |
| halt_cfg | input | 1 | 1: halt is granted; 0: halt request becomes a reset |
| long_dly | input | 1 | Selects the long restart delay |
| halt_req | input | 1 | Request to enter halt |
| ahalt_req | input | 1 | Request to enter active-halt |
| wake_irq | input | 1 | Wake-up interrupt |
| wdg_rst | output | 1 | Reset output |
| halt_ok | output | 1 | Device may sleep (halt or active-halt granted) |
| wdg_on | output | 1 | Timer active |
| count | output | CW | Current counter value |

## Verification
The bench builds the block with PW = 4, DLY_S = 4 and DLY_L = 12. With these values one tick is 16 cycles and the two restart delays are 4 and 12 cycles. A full run from 7Fh down to expiry, each reset pulse, and both wake paths therefore fit in a few thousand cycles. Each scenario, from the early and the in-window writes to the halt variants and the hardware option, can then be driven to its end and checked against the behavioural reference cycle by cycle.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CW    = 7,
  parameter int PW    = 14,
  parameter int DLY_S = 256,
  parameter int DLY_L = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_win,
  input  logic [CW:0]   wr_data,
  input  logic          hw_wdg,
  input  logic          halt_cfg,
  input  logic          long_dly,
  input  logic          halt_req,
  input  logic          ahalt_req,
  input  logic          wake_irq,
  output logic          wdg_rst,
  output logic          halt_ok,
  output logic          wdg_on,
  output logic [CW-1:0] count
);
  localparam int DW = $clog2(DLY_L + 1);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  typedef enum logic [2:0] {S_RUN, S_DLY, S_HALT, S_AHALT, S_BITE} st_t;

  st_t            st;
  logic           en;
  logic [CW-1:0]  cnt, win;
  logic [PW-1:0]  pre;
  logic [DW-1:0]  dc;

  wire            act   = en | hw_wdg;
  wire            tick  = &pre;
  wire [CW-1:0]   dec   = cnt - 1'b1;
  wire            early = act && (cnt > win);
  wire            lowld = (en | wr_data[CW] | hw_wdg) && !wr_data[CW-1];
  wire [DW-1:0]   lim   = long_dly ? DW'(DLY_L - 1) : DW'(DLY_S - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_DLY;
      en  <= 1'b0;
      cnt <= FULL;
      win <= FULL;
      pre <= '0;
      dc  <= '0;
    end else begin
      pre <= ((st == S_RUN && act) || st == S_BITE) ? pre + 1'b1 : '0;
      case (st)
        S_RUN, S_DLY: begin
          if (st == S_DLY) begin
            if (dc == lim) begin
              dc <= '0;
              st <= S_RUN;
            end else begin
              dc <= dc + 1'b1;
            end
          end
          if (wr_win) win <= wr_data[CW-1:0];
          if (wr_ctrl) begin
            pre <= '0;
            if (early || lowld) begin
              st <= S_BITE;
            end else begin
              cnt <= wr_data[CW-1:0];
              en  <= en | wr_data[CW];
            end
          end else if (st == S_RUN) begin
            if (halt_req) begin
              if (act && !halt_cfg) begin
                st  <= S_BITE;
                pre <= '0;
              end else begin
                if (act) cnt <= dec;
                st <= S_HALT;
              end
            end else if (ahalt_req) begin
              st <= S_AHALT;
            end else if (act && tick) begin
              cnt <= dec;
              if (!dec[CW-1]) st <= S_BITE;
            end
          end
        end
        S_HALT: if (wake_irq) begin
          st <= S_DLY;
          dc <= '0;
        end
        S_AHALT: if (wake_irq) st <= S_RUN;
        S_BITE: if (tick) begin
          st  <= S_DLY;
          cnt <= FULL;
          win <= FULL;
          en  <= 1'b0;
          dc  <= '0;
        end
        default: st <= S_DLY;
      endcase
    end
  end

  assign wdg_rst = (st == S_BITE);
  assign halt_ok = (st == S_HALT) || (st == S_AHALT);
  assign wdg_on  = act;
  assign count   = cnt;
endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk #(
  parameter int CW = 7,
  parameter int PW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ctrl,
  input logic          hw_wdg,
  input logic          wdg_rst,
  input logic          halt_ok,
  input logic          wdg_on,
  input logic [CW-1:0] count
);
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else        run <= wdg_rst ? run + 1 : 0;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count == {CW{1'b1}} && !wdg_rst && !halt_ok));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_ctrl) && !$past(wdg_rst)) |->
      (count == $past(count) || count == CW'($past(count) - 1'b1)));

  p_expire_bites_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(count[CW-1]) && !halt_ok) |-> wdg_rst);

  p_bite_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> (run < (1 << PW)));

  p_bite_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdg_rst) |-> (count == {CW{1'b1}} && (wdg_on == hw_wdg)));

  p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdg_on) |-> ($past(wdg_rst) || $fell(hw_wdg)));

  p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_ok && $past(halt_ok)) |-> ($stable(count) && !wdg_rst));
endmodule

bind window_watchdog window_watchdog_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .hw_wdg(hw_wdg),
  .wdg_rst(wdg_rst), .halt_ok(halt_ok), .wdg_on(wdg_on), .count(count)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
  localparam int CW = 7, PW = 4, DS = 4, DL = 12, P = 16;
  localparam int M_RUN = 0, M_DLY = 1, M_HALT = 2, M_AHALT = 3, M_BITE = 4;

  logic clk = 0, rst_n = 0;
  logic wr_ctrl = 0, wr_win = 0, hw_wdg = 0, halt_cfg = 0, long_dly = 0;
  logic halt_req = 0, ahalt_req = 0, wake_irq = 0;
  logic [CW:0] wr_data = 0;
  logic wdg_rst, halt_ok, wdg_on;
  logic [CW-1:0] count;

  int tests = 0, fails = 0, cycles = 0;
  int ms, mc, mw, me, mp, md;

  window_watchdog #(.CW(CW), .PW(PW), .DLY_S(DS), .DLY_L(DL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_win(wr_win), .wr_data(wr_data),
    .hw_wdg(hw_wdg), .halt_cfg(halt_cfg), .long_dly(long_dly), .halt_req(halt_req),
    .ahalt_req(ahalt_req), .wake_irq(wake_irq), .wdg_rst(wdg_rst), .halt_ok(halt_ok),
    .wdg_on(wdg_on), .count(count));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int ns, nc, nw, ne, np, nd, act, lim, v, b7;
    if (!rst_n) begin
      ms = M_DLY; mc = 127; mw = 127; me = 0; mp = 0; md = 0;
    end else begin
      act = me | int'(hw_wdg);
      lim = long_dly ? DL : DS;
      ns = ms; nc = mc; nw = mw; ne = me; nd = md;
      np = ((ms == M_RUN && act != 0) || ms == M_BITE) ? (mp + 1) % P : 0;
      if (ms == M_RUN || ms == M_DLY) begin
        if (ms == M_DLY) begin
          if (md == lim - 1) begin nd = 0; ns = M_RUN; end
          else nd = md + 1;
        end
        if (wr_win) nw = int'(wr_data) % 128;
        if (wr_ctrl) begin
          np = 0;
          v = int'(wr_data) % 128;
          b7 = int'(wr_data) / 128;
          if ((act != 0 && mc > mw) || ((me | b7 | int'(hw_wdg)) != 0 && v < 64)) ns = M_BITE;
          else begin nc = v; ne = me | b7; end
        end else if (ms == M_RUN) begin
          if (halt_req) begin
            if (act != 0 && !halt_cfg) begin ns = M_BITE; np = 0; end
            else begin if (act != 0) nc = mc - 1; ns = M_HALT; end
          end else if (ahalt_req) ns = M_AHALT;
          else if (act != 0 && mp == P - 1) begin
            nc = mc - 1;
            if (nc < 64) ns = M_BITE;
          end
        end
      end else if (ms == M_HALT) begin
        if (wake_irq) begin ns = M_DLY; nd = 0; end
      end else if (ms == M_AHALT) begin
        if (wake_irq) ns = M_RUN;
      end else if (ms == M_BITE && mp == P - 1) begin
        ns = M_DLY; nc = 127; nw = 127; ne = 0; nd = 0;
      end
      ms = ns; mc = nc; mw = nw; me = ne; mp = np; md = nd;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2 count vs model", int'(count), mc);
      check("R3 wdg_rst vs model", int'(wdg_rst), int'(ms == M_BITE));
      check("R8 halt_ok vs model", int'(halt_ok), int'(ms == M_HALT || ms == M_AHALT));
      check("R6 wdg_on vs model", int'(wdg_on), int'(me != 0 || hw_wdg));
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input bit ctl, input logic [CW:0] d);
    @(posedge clk); #3;
    wr_data = d; wr_ctrl = ctl; wr_win = !ctl;
    @(posedge clk); #3;
    wr_ctrl = 0; wr_win = 0;
  endtask

  task automatic strobe(input int which);
    @(posedge clk); #3;
    case (which)
      0: halt_req = 1;
      1: ahalt_req = 1;
      default: wake_irq = 1;
    endcase
    @(posedge clk); #3;
    halt_req = 0; ahalt_req = 0; wake_irq = 0;
  endtask

  task automatic wait_bite_end();
    while (wdg_rst) @(negedge clk);
    repeat (14) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 count at reset", int'(count), 'h7F);
    check("R1 wdg_rst at reset", int'(wdg_rst), 0);
    check("R1 halt_ok at reset", int'(halt_ok), 0);
    check("R1 wdg_on at reset", int'(wdg_on), 0);
    @(posedge clk); #3 rst_n = 1;
    repeat (6) @(posedge clk);

    wr(0, 8'h50);
    wr(1, 8'hFF);
    repeat (40) @(posedge clk); #5;
    check("R2 two ticks after load", int'(count), 'h7D);
    check("R6 enabled by bit7", int'(wdg_on), 1);

    wr(1, 8'hFF); #2;
    check("R4 early write bites", int'(wdg_rst), 1);
    check("R4 early write keeps count", int'(count), 'h7D);
    repeat (15) @(posedge clk); #5;
    check("R3 pulse still high", int'(wdg_rst), 1);
    @(posedge clk); #5;
    check("R3 pulse length", int'(wdg_rst), 0);
    check("R3 count after pulse", int'(count), 'h7F);
    check("R6 enable cleared by pulse", int'(wdg_on), 0);
    repeat (6) @(posedge clk);

    wr(0, 8'h70);
    wr(1, 8'hFF);
    while (count > 7'h70) @(negedge clk);
    wr(1, 8'h7A); #2;
    check("R4 in-window write accepted", int'(count), 'h7A);
    check("R4 no bite in window", int'(wdg_rst), 0);
    check("R6 bit7 zero keeps enable", int'(wdg_on), 1);

    while (!wdg_rst) @(negedge clk);
    check("R3 bite at 3Fh", int'(count), 'h3F);
    wait_bite_end();

    wr(1, 8'hFF);
    wr(1, 8'hB0); #2;
    check("R5 bit6 zero bites", int'(wdg_rst), 1);
    wait_bite_end();

    halt_cfg = 0;
    wr(1, 8'hFF);
    strobe(0); #2;
    check("R7 halt becomes reset", int'(wdg_rst), 1);
    check("R7 halt not granted", int'(halt_ok), 0);
    wait_bite_end();

    halt_cfg = 1; long_dly = 1;
    wr(1, 8'hFF);
    repeat (20) @(posedge clk);
    strobe(0); #2;
    check("R8 halt granted", int'(halt_ok), 1);
    check("R8 one decrement on halt", int'(count), 'h7D);
    repeat (100) @(posedge clk); #5;
    check("R8 frozen in halt", int'(count), 'h7D);
    check("R8 no bite in halt", int'(wdg_rst), 0);
    wr(1, 8'hFF); #2;
    check("R13 write ignored in halt", int'(count), 'h7D);
    strobe(2); #2;
    check("R9 wake clears halt_ok", int'(halt_ok), 0);
    repeat (26) @(posedge clk); #5;
    check("R9 held during long delay", int'(count), 'h7D);
    repeat (4) @(posedge clk); #5;
    check("R9 resumes after delay", int'(count), 'h7C);

    halt_cfg = 0;
    strobe(1); #2;
    check("R10 active-halt granted", int'(halt_ok), 1);
    check("R10 no decrement", int'(count), 'h7C);
    check("R10 no reset with cfg 0", int'(wdg_rst), 0);
    repeat (50) @(posedge clk); #5;
    check("R10 frozen", int'(count), 'h7C);
    strobe(2);
    repeat (18) @(posedge clk); #5;
    check("R10 immediate resume", int'(count), 'h7B);

    @(posedge clk); #3 rst_n = 0; hw_wdg = 1;
    repeat (2) @(posedge clk); #3 rst_n = 1;
    repeat (26) @(posedge clk); #5;
    check("R11 held after reset", int'(count), 'h7F);
    check("R12 hw option active", int'(wdg_on), 1);
    repeat (4) @(posedge clk); #5;
    check("R11 counts after delay", int'(count), 'h7E);
    wr(1, 8'h7F); #2;
    check("R12 reload without enable bit", int'(count), 'h7F);
    check("R12 no bite on reload", int'(wdg_rst), 0);
    strobe(0); #2;
    check("R12 hw bites on halt", int'(wdg_rst), 1);
    wait_bite_end(); #5;
    check("R12 on after pulse", int'(wdg_on), 1);

    repeat (5) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule